// File: doc/BRIEF.md
# Data Translation Fault Classifier and Exception Capture

This block sits after the match array of a fully associative unified translation buffer. On every data access it receives one match bit per buffer entry and sorts the outcome into one of three cases. A single match is a good translation. No match is a translation miss. Two or more matches are a multiple-hit fault, which is handled as a reset-class event. A single match returns the index of the matching entry. A fault loads the exception control registers and issues a redirect of the fetch PC.

A miss stores the faulting address and its page number. It also stores an event code that depends on whether the access reads or writes. Cache maintenance operations are sorted onto the read side or the write side. The miss saves the return PC, the status word and general register 15, then raises the privilege, exception-block and bank bits in the new status word. A multiple hit records only the address and its own code, then jumps to the fixed reset vector. A miss that arrives while exceptions are blocked is not taken. It is flagged on a separate output instead.

Top module: `tlb_fault_entry`

## Requirements
- R1: When `accValid` is high and exactly one bit of `matchVec` is set, `xlateValid` pulses on the next edge with `xlateIndex` equal to that bit's position, and no captured register changes.
- R2: When `accValid` is high and two or more match bits are set, the next edge loads `faultAddr` with the access address, sets `eventCode` to 0x140, pulses `redirect` with `redirectPc` = 0xA000_0000, and leaves all other captured registers unchanged. This applies even when the block bit is set.
- R3: A taken miss (no match bits) loads `faultAddr` with the full address and `pteHi[31:10]` with address bits [31:10]. `pteHi[9:0]` keeps its old value.
- R4: The `accKind` encodings are 0 load, 1 store, 2 purge, 3 write-back, 4 invalidate, 5 allocate-store, and 6 and 7 are treated as loads. A taken miss writes `eventCode` 0x060 for kinds 1, 4 and 5, and 0x040 for every other kind.
- R5: A taken miss loads `savedPc` with `curPc`. When `inDelaySlot` is high, it loads `branchPc` instead.
- R6: A taken miss copies `statusIn` to `savedStatus` and `gr15In` to `savedGr`.
- R7: A taken miss sets `statusOut` to `statusIn` with bits 30 (privileged mode), 29 (register bank) and 28 (exception block) forced to 1.
- R8: A miss with `statusIn[28]` = 1 is not taken. `nestedFault` pulses on the next edge, `redirect` stays low, and no captured register changes.
- R9: A taken miss pulses `redirect` with `redirectPc` = `vecBase` + 0x400.
- R10: Every update and pulse appears on the first edge after the access. The pulses `redirect`, `xlateValid` and `nestedFault` last one cycle, at most one of them is high at a time, and none of them appears when `accValid` is low.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A data access is presented this cycle |
| accAddr | input | 32 | Virtual address of the access |
| accKind | input | 3 | Access kind (encoding in R4) |
| curPc | input | 32 | PC of the accessing instruction |
| inDelaySlot | input | 1 | Instruction sits in a delay slot |
| branchPc | input | 32 | PC of the delayed branch |
| statusIn | input | 32 | Current status word |
| gr15In | input | 32 | Current general register 15 |
| vecBase | input | 32 | Exception vector base |
| matchVec | input | 16 | Per-entry match bits |
| faultAddr | output | 32 | Captured fault address |
| pteHi | output | 32 | Page-table-entry-high register |
| eventCode | output | 12 | Captured event code |
| savedPc | output | 32 | Saved return PC |
| savedStatus | output | 32 | Saved status word |
| savedGr | output | 32 | Saved general register 15 |
| statusOut | output | 32 | Status word written on a taken miss |
| redirect | output | 1 | Fetch redirect strobe |
| redirectPc | output | 32 | Redirect target |
| xlateValid | output | 1 | Single-hit strobe |
| xlateIndex | output | 4 | Index of the matching entry |
| nestedFault | output | 1 | Miss raised while exceptions are blocked |

## Verification
Every captured register is visible at a port, and every event updates them on the very next edge. A wrong classification or a wrong save therefore shows up as a port mismatch one cycle after the access. A fault that wrongly writes a register it should leave alone stays visible until the next write to that register. For this reason the bench compares every register on every cycle, not only on strobe cycles. The hard cases are a multiple hit while the block bit is set and a blocked miss. In both, the registers must keep their old values, so the stimulus alternates with taken misses to make stale or corrupted values show up.

// File: rtl/tlb_fault_pkg.sv
package tlb_fault_pkg;

  typedef enum logic [2:0] {
    KIND_LOAD  = 3'd0,
    KIND_STORE = 3'd1,
    KIND_PURGE = 3'd2,
    KIND_WBACK = 3'd3,
    KIND_INVAL = 3'd4,
    KIND_ALLOC = 3'd5,
    KIND_RSV6  = 3'd6,
    KIND_RSV7  = 3'd7
  } accKindT;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic takeMulti;
    logic takeMiss;
    logic missWrite;
    logic nested;
    logic hit;
  } tlbStrobeT;

  localparam logic [11:0] EV_MULTI_HIT = 12'h140;
  localparam logic [11:0] EV_MISS_RD   = 12'h040;
  localparam logic [11:0] EV_MISS_WR   = 12'h060;

  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;

  function automatic logic kindIsWrite(accKindT k);
    return (k == KIND_STORE) || (k == KIND_INVAL) || (k == KIND_ALLOC);
  endfunction

endpackage

// File: rtl/tlb_fault_ctrl.sv
module tlb_fault_ctrl
  import tlb_fault_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   accValid,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  input  logic [2:0]             accKind,
  input  logic                   blockBit,
  output tlbStrobeT              strobe,
  output logic [IDX_W-1:0]       hitIdx
);

  // Running "seen one" / "seen two" chain across the entries.
  logic [NUM_ENTRIES:0] seenOne;
  logic [NUM_ENTRIES:0] seenTwo;
  assign seenOne[0] = 1'b0;
  assign seenTwo[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gChain
      assign seenTwo[g+1] = seenTwo[g] | (seenOne[g] & matchVec[g]);
      assign seenOne[g+1] = seenOne[g] | matchVec[g];
    end
  endgenerate

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  logic anyHit;
  logic multiHit;
  assign anyHit   = seenOne[NUM_ENTRIES];
  assign multiHit = seenTwo[NUM_ENTRIES];

  always_comb begin
    strobe           = '0;
    strobe.missWrite = kindIsWrite(accKindT'(accKind));
    if (accValid) begin
      if (multiHit) begin
        strobe.takeMulti = 1'b1;
      end else if (!anyHit) begin
        if (blockBit) strobe.nested   = 1'b1;
        else          strobe.takeMiss = 1'b1;
      end else begin
        strobe.hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_fault_dp.sv
module tlb_fault_dp
  import tlb_fault_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          IDX_W      = 4,
  parameter int          VPN_LSB    = 10,
  parameter logic [31:0] RESET_VEC  = 32'hA000_0000,
  parameter logic [31:0] MISS_OFFS  = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobeT         strobe,
  input  logic [IDX_W-1:0]  hitIdx,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [31:0]       curPc,
  input  logic              inDelaySlot,
  input  logic [31:0]       branchPc,
  input  logic [31:0]       statusIn,
  input  logic [31:0]       gr15In,
  input  logic [31:0]       vecBase,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [ADDR_W-1:0] pteHi,
  output logic [11:0]       eventCode,
  output logic [31:0]       savedPc,
  output logic [31:0]       savedStatus,
  output logic [31:0]       savedGr,
  output logic [31:0]       statusOut,
  output logic              redirect,
  output logic [31:0]       redirectPc,
  output logic              xlateValid,
  output logic [IDX_W-1:0]  xlateIndex,
  output logic              nestedFault
);

  localparam int VPN_W = ADDR_W - VPN_LSB;

  logic [31:0] raiseMask;
  always_comb begin
    raiseMask = '0;
    raiseMask[SR_MD_BIT] = 1'b1;
    raiseMask[SR_RB_BIT] = 1'b1;
    raiseMask[SR_BL_BIT] = 1'b1;
  end

  logic anyFault;
  assign anyFault = strobe.takeMulti | strobe.takeMiss;

  // Registers written by both fault kinds
  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr  <= '0;
      eventCode  <= '0;
      redirectPc <= '0;
    end else if (anyFault) begin
      faultAddr <= accAddr;
      if (strobe.takeMulti) begin
        eventCode  <= EV_MULTI_HIT;
        redirectPc <= RESET_VEC;
      end else begin
        eventCode  <= strobe.missWrite ? EV_MISS_WR : EV_MISS_RD;
        redirectPc <= vecBase + MISS_OFFS;
      end
    end
  end

  // Registers written only by a taken miss
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pteHi       <= '0;
      savedPc     <= '0;
      savedStatus <= '0;
      savedGr     <= '0;
      statusOut   <= '0;
    end else if (strobe.takeMiss) begin
      pteHi[ADDR_W-1:VPN_LSB] <= accAddr[ADDR_W-1:VPN_LSB];
      savedPc     <= inDelaySlot ? branchPc : curPc;
      savedStatus <= statusIn;
      savedGr     <= gr15In;
      statusOut   <= statusIn | raiseMask;
    end
  end

  // One-cycle strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirect    <= 1'b0;
      xlateValid  <= 1'b0;
      xlateIndex  <= '0;
      nestedFault <= 1'b0;
    end else begin
      redirect    <= anyFault;
      xlateValid  <= strobe.hit;
      nestedFault <= strobe.nested;
      if (strobe.hit) xlateIndex <= hitIdx;
    end
  end

  logic [VPN_W-1:0] unusedVpn;
  assign unusedVpn = '0;

endmodule

// File: rtl/tlb_fault_entry.sv
module tlb_fault_entry
  import tlb_fault_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accValid,
  input  logic [31:0]            accAddr,
  input  logic [2:0]             accKind,
  input  logic [31:0]            curPc,
  input  logic                   inDelaySlot,
  input  logic [31:0]            branchPc,
  input  logic [31:0]            statusIn,
  input  logic [31:0]            gr15In,
  input  logic [31:0]            vecBase,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  output logic [31:0]            faultAddr,
  output logic [31:0]            pteHi,
  output logic [11:0]            eventCode,
  output logic [31:0]            savedPc,
  output logic [31:0]            savedStatus,
  output logic [31:0]            savedGr,
  output logic [31:0]            statusOut,
  output logic                   redirect,
  output logic [31:0]            redirectPc,
  output logic                   xlateValid,
  output logic [IDX_W-1:0]       xlateIndex,
  output logic                   nestedFault
);

  tlbStrobeT        strobe;
  logic [IDX_W-1:0] hitIdx;

  tlb_fault_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .accValid (accValid),
    .matchVec (matchVec),
    .accKind  (accKind),
    .blockBit (statusIn[SR_BL_BIT]),
    .strobe   (strobe),
    .hitIdx   (hitIdx)
  );

  tlb_fault_dp #(.ADDR_W(32), .IDX_W(IDX_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hitIdx      (hitIdx),
    .accAddr     (accAddr),
    .curPc       (curPc),
    .inDelaySlot (inDelaySlot),
    .branchPc    (branchPc),
    .statusIn    (statusIn),
    .gr15In      (gr15In),
    .vecBase     (vecBase),
    .faultAddr   (faultAddr),
    .pteHi       (pteHi),
    .eventCode   (eventCode),
    .savedPc     (savedPc),
    .savedStatus (savedStatus),
    .savedGr     (savedGr),
    .statusOut   (statusOut),
    .redirect    (redirect),
    .redirectPc  (redirectPc),
    .xlateValid  (xlateValid),
    .xlateIndex  (xlateIndex),
    .nestedFault (nestedFault)
  );

endmodule

// File: rtl/tlb_fault_chk.sv
module tlb_fault_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   accValid,
  input logic [31:0]            accAddr,
  input logic [NUM_ENTRIES-1:0] matchVec,
  input logic [31:0]            statusIn,
  input logic [31:0]            faultAddr,
  input logic [11:0]            eventCode,
  input logic [31:0]            savedPc,
  input logic [31:0]            savedStatus,
  input logic [31:0]            statusOut,
  input logic                   redirect,
  input logic [31:0]            redirectPc,
  input logic                   xlateValid,
  input logic                   nestedFault
);

  AST_MULTI_HIT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && $countones(matchVec) > 1) |=>
      (redirect && eventCode == 12'h140 && redirectPc == 32'hA000_0000 && faultAddr == $past(accAddr))); // R2

  AST_SINGLE_HIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && $countones(matchVec) == 1) |=>
      (xlateValid && !redirect && $stable(faultAddr) && $stable(savedPc))); // R1

  AST_MISS_RAISES_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && matchVec == '0 && !statusIn[28]) |=> (redirect && statusOut[30:28] == 3'b111)); // R7

  AST_NESTED_NO_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    nestedFault |-> (!redirect && $stable(savedStatus) && $stable(savedPc))); // R8

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({redirect, xlateValid, nestedFault})); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> (!redirect && !xlateValid && !nestedFault)); // R10

endmodule

bind tlb_fault_entry tlb_fault_chk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .accValid    (accValid),
  .accAddr     (accAddr),
  .matchVec    (matchVec),
  .statusIn    (statusIn),
  .faultAddr   (faultAddr),
  .eventCode   (eventCode),
  .savedPc     (savedPc),
  .savedStatus (savedStatus),
  .statusOut   (statusOut),
  .redirect    (redirect),
  .redirectPc  (redirectPc),
  .xlateValid  (xlateValid),
  .nestedFault (nestedFault)
);

// File: tb/sim_tlb_fault_entry.sv
module sim_tlb_fault_entry;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [2:0]  accKind = '0;
  logic [31:0] curPc = '0;
  logic        inDelaySlot = 1'b0;
  logic [31:0] branchPc = '0;
  logic [31:0] statusIn = '0;
  logic [31:0] gr15In = '0;
  logic [31:0] vecBase = '0;
  logic [N-1:0] matchVec = '0;

  logic [31:0] faultAddr, pteHi, savedPc, savedStatus, savedGr, statusOut, redirectPc;
  logic [11:0] eventCode;
  logic        redirect, xlateValid, nestedFault;
  logic [3:0]  xlateIndex;

  always #10 clk = ~clk;  // 50 MHz

  tlb_fault_entry u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr), .accKind(accKind),
    .curPc(curPc), .inDelaySlot(inDelaySlot), .branchPc(branchPc), .statusIn(statusIn),
    .gr15In(gr15In), .vecBase(vecBase), .matchVec(matchVec),
    .faultAddr(faultAddr), .pteHi(pteHi), .eventCode(eventCode), .savedPc(savedPc),
    .savedStatus(savedStatus), .savedGr(savedGr), .statusOut(statusOut),
    .redirect(redirect), .redirectPc(redirectPc), .xlateValid(xlateValid),
    .xlateIndex(xlateIndex), .nestedFault(nestedFault)
  );

  // Behavioural reference model
  logic [31:0] mFault, mPte, mSpc, mSsr, mSgr, mSr, mRpc;
  logic [11:0] mEv;
  logic        mRed, mXv, mNest;
  logic [3:0]  mIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      mFault = 0; mPte = 0; mSpc = 0; mSsr = 0; mSgr = 0; mSr = 0; mRpc = 0;
      mEv = 0; mRed = 0; mXv = 0; mNest = 0; mIdx = 0;
    end else begin
      mRed = 0; mXv = 0; mNest = 0;
      if (accValid) begin
        int hits;
        hits = $countones(matchVec);
        if (hits > 1) begin
          mFault = accAddr; mEv = 12'h140; mRpc = 32'hA000_0000; mRed = 1;
        end else if (hits == 0) begin
          if (statusIn[28]) mNest = 1;
          else begin
            mFault = accAddr;
            mPte = {accAddr[31:10], mPte[9:0]};
            mEv = (accKind == 3'd1 || accKind == 3'd4 || accKind == 3'd5) ? 12'h060 : 12'h040;
            mSpc = inDelaySlot ? branchPc : curPc;
            mSsr = statusIn; mSgr = gr15In;
            mSr = statusIn | 32'h7000_0000;
            mRpc = vecBase + 32'h400; mRed = 1;
          end
        end else begin
          mXv = 1;
          for (int i = 0; i < N; i++) if (matchVec[i]) mIdx = 4'(i);
        end
      end
    end
  end

  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string tR;
      tR = rstN ? "" : "R11";
      chk(rstN ? "R2"  : tR, "faultAddr",   faultAddr,   mFault);
      chk(rstN ? "R3"  : tR, "pteHi",       pteHi,       mPte);
      chk(rstN ? "R4"  : tR, "eventCode",   32'(eventCode), 32'(mEv));
      chk(rstN ? "R5"  : tR, "savedPc",     savedPc,     mSpc);
      chk(rstN ? "R6"  : tR, "savedStatus", savedStatus, mSsr);
      chk(rstN ? "R6"  : tR, "savedGr",     savedGr,     mSgr);
      chk(rstN ? "R7"  : tR, "statusOut",   statusOut,   mSr);
      chk(rstN ? "R9"  : tR, "redirectPc",  redirectPc,  mRpc);
      chk(rstN ? "R10" : tR, "redirect",    32'(redirect), 32'(mRed));
      chk(rstN ? "R1"  : tR, "xlateValid",  32'(xlateValid), 32'(mXv));
      chk(rstN ? "R1"  : tR, "xlateIndex",  32'(xlateIndex), 32'(mIdx));
      chk(rstN ? "R8"  : tR, "nestedFault", 32'(nestedFault), 32'(mNest));
    end
  end

  task automatic access(logic [31:0] a, logic [2:0] k, logic ds, logic [31:0] sr, logic [N-1:0] mv);
    @(negedge clk);
    accValid = 1; accAddr = a; accKind = k; inDelaySlot = ds; statusIn = sr; matchVec = mv;
    curPc = a ^ 32'h1357_9bdf; branchPc = curPc - 32'd2; gr15In = ~a;
    vecBase = 32'h8000_0000 | {a[11:4], 4'h0};
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 0; matchVec = $urandom;  // ignored while no access
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R3 R5 R6 R7 R9: taken miss, load, not delay slot
    access(32'h1234_5678, 3'd0, 0, 32'h0000_00F0, '0);
    // R4: each kind on a miss, R5 delay slot
    for (int k = 0; k < 8; k++) access(32'hC0DE_0000 + 32'(k << 12), 3'(k), k[0], 32'h0000_0001, '0);
    // R1: single hits at the ends and middle
    access(32'h0, 3'd1, 0, 0, 16'h0001);
    access(32'h0, 3'd1, 0, 0, 16'h8000);
    access(32'h0, 3'd1, 0, 0, 16'h0100);
    // R2: multiple hit, also while blocked
    access(32'hDEAD_BEEF, 3'd0, 0, 0, 16'h0011);
    access(32'hFACE_0001, 3'd1, 0, 32'h1000_0000, 16'hFFFF);
    // R8: blocked miss
    access(32'h5555_AAAA, 3'd1, 1, 32'h1000_0000, '0);
    // R10: idle cycles with stray match bits
    idle(); idle();
    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [N-1:0] mv;
      sel = $urandom_range(0, 5);
      case (sel)
        0, 1: mv = '0;
        2, 3: mv = N'(1) << $urandom_range(0, N-1);
        4:    mv = (N'(1) << $urandom_range(0, 7)) | (N'(1) << $urandom_range(8, N-1));
        default: mv = N'($urandom);
      endcase
      if (sel == 5 && n[2]) idle();
      else access($urandom, 3'($urandom), 1'($urandom), {3'b000, ($urandom_range(0,3) == 0), 28'($urandom)}, mv);
    end
    idle();
    // R11: reset returns outputs to zero
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      missCount++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule